// File: doc/BRIEF.md
# Qualified Bus Ready Synchroniser

This block merges two bus-ready requests into the single ready level a processor samples to end a bus cycle. Each request is gated by its own active-low enable, so only a device whose enable is held low can finish the transfer. The merged level is then registered against the processor clock, so that the CPU sees a clean ready that changes only at a clock falling edge.

A mode input picks the synchronisation path. With the mode input high, the merged level goes through one falling-edge register, which suits ready sources that already meet setup to the clock. With the mode input low, an asserting ready must first be caught on a rising edge and then again on the following falling edge. This gives an asynchronous source a full stage to settle. A deasserting ready skips the rising-edge stage and drops the output at the very next falling edge, so the processor is never released late. A synchronous reset clears both registers.

Top module: `rdy_sync`

## Requirements
- R1: While `rst` is high at a clock edge, both registers clear; `ready_out` is low after every falling edge at which `rst` was high.
- R2: `rdy_a` affects `ready_out` only while `en_a_n` is low; with `en_a_n` high, a high `rdy_a` leaves `ready_out` low.
- R3: `rdy_b` affects `ready_out` only while `en_b_n` is low; with `en_b_n` high, a high `rdy_b` leaves `ready_out` low.
- R4: The merged request is high when at least one enabled ready input is high (a logical OR of the two gated inputs).
- R5: With `one_stage` high at a falling edge, `ready_out` takes the merged request level seen at that falling edge, for both rising and falling transitions.
- R6: With `one_stage` low, `ready_out` goes high at a falling edge only if the merged request was high at the preceding rising edge and is still high at that falling edge; a request that rises after the rising edge shows one falling edge later.
- R7: With `one_stage` low, a merged request that is low at a falling edge drives `ready_out` low at that same falling edge, whatever the first stage holds.
- R8: `one_stage` is sampled at each falling edge, so a change of mode takes effect at the first falling edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; first stage on the rising edge, output stage on the falling edge |
| rst | input | 1 | Synchronous reset, active high |
| rdy_a | input | 1 | First bus-ready request, high means the transfer is done |
| en_a_n | input | 1 | Active-low enable for `rdy_a` |
| rdy_b | input | 1 | Second bus-ready request, high means the transfer is done |
| en_b_n | input | 1 | Active-low enable for `rdy_b` |
| one_stage | input | 1 | High selects the single falling-edge path; low selects the two-stage path. Tie it high when unused |
| ready_out | output | 1 | Synchronised ready to the processor |

## Verification
The bench changes the request between a rising and the next falling edge in two-stage mode. A design that fed the output stage straight from the merged level would then raise ready a falling edge too early, and one that also sent deassertion through the first stage would release the processor a cycle late. It also holds a ready high with its enable high, where a missing or inverted gate shows up as a spurious ready. It flips the mode in the middle of a request to catch a mode input that is latched at the wrong edge. It asserts reset while the request is high in both modes, so a reset that misses either register leaks a ready.

// File: rtl/rdy_sync.sv
module rdy_sync (
  input  logic clk,
  input  logic rst,
  input  logic rdy_a,
  input  logic en_a_n,
  input  logic rdy_b,
  input  logic en_b_n,
  input  logic one_stage,
  output logic ready_out
);

  logic req;
  logic stage1;

  assign req = (rdy_a & ~en_a_n) | (rdy_b & ~en_b_n);

  always_ff @(posedge clk) begin
    if (rst) stage1 <= 1'b0;
    else     stage1 <= req;
  end

  always_ff @(negedge clk) begin
    if (rst)            ready_out <= 1'b0;
    else if (one_stage) ready_out <= req;
    else                ready_out <= stage1 & req;
  end

endmodule

module rdy_sync_chk (
  input logic clk,
  input logic rst,
  input logic rdy_a,
  input logic en_a_n,
  input logic rdy_b,
  input logic en_b_n,
  input logic one_stage,
  input logic ready_out
);

  logic merged;
  assign merged = (rdy_a && !en_a_n) || (rdy_b && !en_b_n);

  // R1
  reset_low_chk: assert property (@(negedge clk) disable iff (rst)
    $fell(rst) |-> !ready_out);

  // R2 R3 R4
  gate_chk: assert property (@(negedge clk) disable iff (rst)
    (!$past(rst) && ready_out) |-> $past(merged));

  // R5
  single_follow_chk: assert property (@(negedge clk) disable iff (rst)
    (!$past(rst) && $past(one_stage)) |-> (ready_out == $past(merged)));

  // R6
  two_rise_chk: assert property (@(negedge clk) disable iff (rst)
    (!$past(rst) && !$past(one_stage) && $rose(ready_out)) |-> $past(merged));

  // R7
  two_fall_chk: assert property (@(negedge clk) disable iff (rst)
    (!$past(rst) && !$past(one_stage) && !$past(merged)) |-> !ready_out);

endmodule

bind rdy_sync rdy_sync_chk u_chk (
  .clk(clk), .rst(rst), .rdy_a(rdy_a), .en_a_n(en_a_n),
  .rdy_b(rdy_b), .en_b_n(en_b_n), .one_stage(one_stage),
  .ready_out(ready_out)
);

// File: tb/rdy_sync_bench.sv
module rdy_sync_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst, rdy_a, en_a_n, rdy_b, en_b_n, one_stage;
  logic ready_out;
  int errors = 0;
  int checks = 0;
  logic held;

  always #(CLK_P/2) clk = ~clk;

  rdy_sync u_rdy_sync (
    .clk(clk), .rst(rst), .rdy_a(rdy_a), .en_a_n(en_a_n),
    .rdy_b(rdy_b), .en_b_n(en_b_n), .one_stage(one_stage),
    .ready_out(ready_out)
  );

  function automatic logic wanted();
    return (rdy_a === 1'b1 && en_a_n === 1'b0) || (rdy_b === 1'b1 && en_b_n === 1'b0);
  endfunction

  task automatic apply(input logic ra, input logic ean, input logic rb,
                       input logic ebn, input logic md, input logic r);
    rdy_a = ra; en_a_n = ean; rdy_b = rb; en_b_n = ebn; one_stage = md; rst = r;
  endtask

  // late = 1 changes the inputs after the rising edge instead of before it
  task automatic step(input logic ra, input logic ean, input logic rb,
                      input logic ebn, input logic md, input logic r,
                      input logic late, input string tag);
    logic exp;
    if (!late) apply(ra, ean, rb, ebn, md, r);
    @(posedge clk);
    held = rst ? 1'b0 : wanted();
    if (late) begin
      #1;
      apply(ra, ean, rb, ebn, md, r);
    end
    @(negedge clk);
    if (rst)            exp = 1'b0;
    else if (one_stage) exp = wanted();
    else                exp = held & wanted();
    #1;
    checks++;
    if (ready_out !== exp) begin
      errors++;
      $display("FAIL %s at %0t: ready_out=%b expected=%b", tag, $time, ready_out, exp);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    held = 1'b0;
    apply(1, 0, 1, 0, 1, 1);
    @(negedge clk); #1;
    // R1 reset holds output low with an enabled high request
    step(1, 0, 1, 0, 1, 1, 0, "R1");
    step(1, 0, 1, 0, 0, 1, 0, "R1");
    step(0, 1, 0, 1, 1, 0, 0, "R1");
    // R2 first input gated by its enable
    step(1, 1, 0, 1, 1, 0, 0, "R2");
    step(1, 1, 0, 0, 1, 0, 0, "R2");
    step(1, 0, 0, 1, 1, 0, 0, "R2");
    step(0, 0, 0, 1, 1, 0, 0, "R2");
    // R3 second input gated by its enable
    step(0, 1, 1, 1, 1, 0, 0, "R3");
    step(0, 0, 1, 1, 1, 0, 0, "R3");
    step(0, 1, 1, 0, 1, 0, 0, "R3");
    step(0, 1, 0, 0, 1, 0, 0, "R3");
    // R4 OR of the gated inputs
    step(1, 0, 0, 0, 1, 0, 0, "R4");
    step(0, 0, 1, 0, 1, 0, 0, "R4");
    step(1, 0, 1, 0, 1, 0, 0, "R4");
    step(1, 1, 1, 0, 1, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 0, 0, "R4");
    // R5 single stage follows at the falling edge, including late changes
    step(1, 0, 0, 1, 1, 0, 1, "R5");
    step(0, 0, 0, 1, 1, 0, 1, "R5");
    step(1, 0, 0, 1, 1, 0, 0, "R5");
    step(0, 0, 0, 1, 1, 0, 0, "R5");
    // R6 two-stage rise, early and late
    step(0, 0, 0, 1, 0, 0, 0, "R6");
    step(1, 0, 0, 1, 0, 0, 0, "R6");
    step(1, 0, 0, 1, 0, 0, 0, "R6");
    step(0, 0, 0, 1, 0, 0, 0, "R7");
    step(0, 0, 1, 0, 0, 0, 1, "R6");
    step(0, 0, 1, 0, 0, 0, 0, "R6");
    // R7 two-stage fall at the same falling edge, even when late
    step(0, 0, 0, 0, 0, 0, 1, "R7");
    step(1, 0, 0, 1, 0, 0, 0, "R6");
    step(1, 1, 0, 1, 0, 0, 1, "R7");
    // R8 mode switch mid request
    step(0, 0, 0, 1, 0, 0, 0, "R8");
    step(1, 0, 0, 1, 1, 0, 1, "R8");
    step(0, 0, 0, 1, 1, 0, 0, "R8");
    step(1, 0, 0, 1, 0, 0, 1, "R8");
    step(1, 0, 0, 1, 0, 0, 0, "R8");
    // R1 reset mid-run in two-stage mode, then recovery
    step(1, 0, 0, 1, 0, 1, 0, "R1");
    step(1, 0, 0, 1, 0, 0, 1, "R1");
    step(1, 0, 0, 1, 0, 0, 0, "R6");
    for (int i = 0; i < 8; i++)
      step(logic'(i[0]), logic'(i[1]), logic'(i[2]), 1'b0, logic'(i[1] ^ i[2]), 1'b0, logic'(i[0] ^ i[2]), "R4");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule